// File: doc/BRIEF.md
# Register-Bank Exchange Sorter

This block keeps a small bank of K unsigned words and puts them into ascending order in place. A host first fills the bank through a load port (data, slot address, write strobe) while the unit is idle. It then raises `start` and waits for `done`, and after that reads the sorted words back one slot at a time through a registered read port.

Sorting is sequential and uses a single comparator. An outer index `i` walks from slot 0 to slot K-2, and an inner index `j` walks from `i+1` to K-1. Two holding registers keep a copy of the word at `i` (A) and of the word at `j` (B). When B is strictly smaller than A, the two words trade places in the bank over two write cycles, and A is then refreshed from slot `i`. Each write into the bank goes through one address mux and one decoder that makes per-slot enables. The same bank serves the host load port and the sorter's write-back, so it has exactly one write port.

Top module: `xsort_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit returns to idle, both indices clear, `done` reads 0 and `rd_data` reads 0 after that edge.
- R2: In idle, a rising edge with `init_we` high stores `init_data` into slot `init_addr`.
- R3: In idle or finished state, `rd_data` shows the contents of slot `rd_addr` one rising edge after the address is presented.
- R4: A rising edge that samples `start` high in idle begins a sort. When `done` goes high, slot 0 through slot K-1 hold the original words in non-decreasing unsigned order.
- R5: An exchange happens only when the inner word is strictly less than the current outer word, so equal words are never exchanged. Each exchange adds two cycles. The edge that raises `done` is the K*K-th rising edge counted from (and including) the edge that sampled `start`, plus 2 per exchange.
- R6: `done` stays high while `start` stays high, and falls at the first rising edge that samples `start` low.
- R7: Load-port writes presented while a sort is in progress have no effect on the bank.
- R8: Read addresses presented while a sort is in progress are ignored, and `rd_data` holds its value.
- R9: While the sort steps through the bank, the inner index is always above the outer index and never exceeds K-1, and neither index steps past its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_we | input | 1 | Load-port write strobe |
| init_addr | input | AW | Load-port slot address |
| init_data | input | W | Load-port data |
| start | input | 1 | Begin sort; hold high until done is seen |
| rd_addr | input | AW | Read-port slot address |
| rd_data | output | W | Registered read data |
| done | output | 1 | Sort complete |

## Verification
The hardest thing to reach from the ports is an exact count of exchanges. It depends on how A is refreshed after each exchange and on ties not being swapped, and the outputs show it only as the latency of `done`. The bench replays the comparison rule on its own copy of the words to predict the exchange count. It also uses input patterns with many duplicates, already-sorted and reversed orders, and random words from a narrow value range so that ties are frequent. Load writes and read-address changes are injected in the middle of a sort to show they leave no trace.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDA,
    ST_LDB,
    ST_CMP,
    ST_WRJ,
    ST_RLA,
    ST_DONE
  } sort_state_e;
endpackage

// File: rtl/xsort_index_ctr.sv
module xsort_index_ctr #(
  parameter int AW   = 2,
  parameter int LAST = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] q,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST_V = AW'(LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (load)   q <= load_val;
    else if (step)   q <= q + 1'b1;
  end

  assign at_last = (q == LAST_V);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (q != '0));
endmodule

// File: rtl/xsort_regbank.sv
module xsort_regbank #(
  parameter int W  = 8,
  parameter int K  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_int,
  output logic [W-1:0]  rdata_int,
  input  logic [AW-1:0] raddr_ext,
  output logic [W-1:0]  rdata_ext
);
  logic [W-1:0] slot [K];
  logic [K-1:0] wsel;

  for (genvar g = 0; g < K; g++) begin : g_slot
    assign wsel[g] = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (wsel[g]) slot[g] <= wdata;
    end
  end

  assign rdata_int = slot[raddr_int];
  assign rdata_ext = slot[raddr_ext];
endmodule

// File: rtl/xsort_unit.sv
module xsort_unit
  import xsort_pkg::*;
#(
  parameter int W  = 8,
  parameter int K  = 4,
  parameter int AW = (K > 2) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [W-1:0]  init_data,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          done
);
  localparam logic [AW-1:0] TOP_J = AW'(K - 1);

  sort_state_e state, state_nx;
  logic [W-1:0]  a_q, b_q, rdata_int, rdata_ext, wdata;
  logic [AW-1:0] i_q, j_q, waddr, raddr_int;
  logic          i_last, j_last, b_lt_a, advance, we, busy;

  assign b_lt_a  = (b_q < a_q);
  assign advance = ((state == ST_CMP) && !b_lt_a) || (state == ST_RLA);
  assign busy    = (state != ST_IDLE) && (state != ST_DONE);

  xsort_index_ctr #(.AW(AW), .LAST(K - 2)) u_ictr (
    .clk(clk), .rst(rst),
    .clr((state == ST_IDLE) && start),
    .load(1'b0), .load_val('0),
    .step(advance && j_last && !i_last),
    .q(i_q), .at_last(i_last)
  );

  xsort_index_ctr #(.AW(AW), .LAST(K - 1)) u_jctr (
    .clk(clk), .rst(rst),
    .clr(1'b0),
    .load(state == ST_LDA), .load_val(i_q + 1'b1),
    .step(advance && !j_last),
    .q(j_q), .at_last(j_last)
  );

  always_comb begin
    we    = 1'b0;
    waddr = i_q;
    wdata = b_q;
    case (state)
      ST_IDLE: begin we = init_we; waddr = init_addr; wdata = init_data; end
      ST_CMP:  we = b_lt_a;
      ST_WRJ:  begin we = 1'b1; waddr = j_q; wdata = a_q; end
      default: ;
    endcase
  end

  assign raddr_int = (state == ST_LDB) ? j_q : i_q;

  xsort_regbank #(.W(W), .K(K), .AW(AW)) u_bank (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_int(raddr_int), .rdata_int(rdata_int),
    .raddr_ext(rd_addr), .rdata_ext(rdata_ext)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_LDA;
      ST_LDA:  state_nx = ST_LDB;
      ST_LDB:  state_nx = ST_CMP;
      ST_CMP:  if (b_lt_a) state_nx = ST_WRJ;
      ST_WRJ:  state_nx = ST_RLA;
      ST_DONE: if (!start) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
    if (advance) begin
      if (!j_last)     state_nx = ST_LDB;
      else if (i_last) state_nx = ST_DONE;
      else             state_nx = ST_LDA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      rd_data <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_LDA || state == ST_RLA) a_q <= rdata_int;
      if (state == ST_LDB) b_q <= rdata_int;
      if (!busy) rd_data <= rdata_ext;
    end
  end

  assign done = (state == ST_DONE);

  // R4
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_LDA));
  // R5
  swap_only_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRJ) |-> ($past(state) == ST_CMP && $past(b_q) < $past(a_q)));
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);
  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);
  // R8
  rd_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));
  // R9
  j_above_i_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_LDA) |-> (j_q > i_q && j_q <= TOP_J));
endmodule

// File: tb/test_xsort_unit.sv
module test_xsort_unit;
  localparam int W = 8;
  localparam int K = 4;
  localparam int AW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_we = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic [W-1:0] init_data = '0;
  logic start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [W-1:0] vin [K];
  logic [W-1:0] vexp [K];
  int swaps;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xsort_unit #(.W(W), .K(K), .AW(AW)) i_xsort_unit (
    .clk(clk), .rst(rst), .init_we(init_we), .init_addr(init_addr),
    .init_data(init_data), .start(start), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model();
    logic [W-1:0] r [K];
    logic [W-1:0] a, b;
    for (int x = 0; x < K; x++) r[x] = vin[x];
    swaps = 0;
    for (int i = 0; i <= K - 2; i++) begin
      a = r[i];
      for (int j = i + 1; j <= K - 1; j++) begin
        b = r[j];
        if (b < a) begin
          r[i] = b; r[j] = a; a = r[i]; swaps++;
        end
      end
    end
    for (int x = 0; x < K; x++) vexp[x] = r[x];
  endfunction

  task automatic load_all();
    for (int x = 0; x < K; x++) begin
      init_we = 1'b1; init_addr = AW'(x); init_data = vin[x];
      @(negedge clk);
    end
    init_we = 1'b0;
  endtask

  task automatic run_sort(input bit poke);
    int cyc;
    logic [W-1:0] held;
    model();
    load_all();
    // R2 R3: slot 1 read back before sorting
    rd_addr = 1; @(negedge clk);
    check("R2", rd_data, vin[1]);
    start = 1'b1;
    @(posedge clk); cyc = 1; @(negedge clk);
    held = rd_data;
    while (!done && cyc < 400) begin
      if (poke && cyc == 3) begin
        init_we = 1'b1; init_addr = 0; init_data = 8'hFF; rd_addr = 3;
      end else begin
        init_we = 1'b0;
      end
      @(posedge clk); cyc++; @(negedge clk);
      if (!done) check("R8", rd_data, held);
    end
    init_we = 1'b0;
    check("R5", cyc, K * K + 2 * swaps);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R6", done, 1);
    end
    start = 1'b0;
    @(negedge clk);
    check("R6", done, 0);
    for (int x = 0; x < K; x++) begin
      rd_addr = AW'(x);
      @(negedge clk);
      if (poke) check("R7", rd_data, vexp[x]);
      else check("R4", rd_data, vexp[x]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    check("R1", done, 0);
    check("R1", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);

    vin = '{8'd1, 8'd2, 8'd3, 8'd4};       run_sort(0);
    vin = '{8'd200, 8'd90, 8'd7, 8'd0};    run_sort(0);
    vin = '{8'd5, 8'd5, 8'd5, 8'd5};       run_sort(0);  // R5 ties
    vin = '{8'd9, 8'd3, 8'd9, 8'd3};       run_sort(0);
    vin = '{8'd255, 8'd0, 8'd255, 8'd128}; run_sort(0);
    vin = '{8'd40, 8'd30, 8'd20, 8'd10};   run_sort(1);  // R7 R8
    for (int t = 0; t < 20; t++) begin
      for (int x = 0; x < K; x++)
        vin[x] = (t % 2 == 0) ? W'($urandom_range(0, 3)) : W'($urandom_range(0, 255));
      run_sort(t % 3 == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule